// File: doc/BRIEF.md
# Power-Supply Control Register Slave on I2C

This block is the serial control port of a supply controller. It is an I2C slave that holds one 8-bit control register. A bus master writes that register to set the output enable, the voltage level, the line-drop compensation, the tone controls and the current-limit mode. The master reads the register back as a status byte. That status byte echoes three of the control bits and adds two live fault flags: over-temperature and over-load.

The slave oversamples SCL and SDA on the system clock. It drives SDA only by pulling it low through an output-enable. The device address is 000101x, where the low bit x is taken from a board-level address-select input.

A supply-good input gates the whole port. While supply-good is low, the slave never drives SDA and the register is held at zero. This keeps every power stage off until the supply is valid again.

Top module: `pwr_ctl_i2c_slave`

## Requirements
- R1: After reset, `ctrl_o` is 8'h00 and `sda_oe_o` is 0 (SDA released).
- R2: The first byte after a START carries a 7-bit address, MSB first, followed by a direction bit (1 = read). The slave pulls SDA low in the ninth clock only when the address equals {6'b000101, `addr_sel_i`}. For any other address SDA stays released for the rest of the transfer.
- R3: Each data byte of a write transfer is acknowledged and stored whole in the register, which appears on `ctrl_o`. The bit layout is [7] pulse-limit mode, [6] tone arm, [5] continuous tone, [4] line compensation, [3] high voltage, [2] output enable, [1:0] test bits. The register keeps its value when no write happens.
- R4: A read byte is sent MSB first as {3'b000, ctrl[4], ctrl[3], ctrl[2], over_temp, over_load}. The test bits written to [1:0] never appear in a read.
- R5: The two fault flags in a read byte are the values of `over_temp_i` and `over_load_i` at the moment the byte is loaded. That moment is the address acknowledge for the first byte, and the master's acknowledge for each later byte. Changes during the byte do not alter it.
- R6: While the master acknowledges a read byte, the slave sends another byte. A master no-acknowledge ends the read, and SDA stays released afterwards.
- R7: While `supply_ok_i` is low, the slave acknowledges nothing and `ctrl_o` is 8'h00. Writes attempted in that state have no effect.
- R8: A STOP, or a repeated START, abandons any transfer in progress. A partly shifted byte is discarded, and a repeated START begins a new address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok_i | input | 1 | Supply above lockout; low silences the port and clears the register |
| addr_sel_i | input | 1 | Low bit of the device address |
| scl_i | input | 1 | I2C clock line |
| sda_i | input | 1 | I2C data line as seen on the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| over_temp_i | input | 1 | Over-temperature fault flag |
| over_load_i | input | 1 | Over-load fault flag |
| ctrl_o | output | 8 | Control register contents |

## Verification
Each SCL edge reaches the state machine three system clocks after it occurs: two synchronizer flops plus one edge-detect flop. Acknowledge and read-data levels on SDA therefore change three to four clocks after an SCL fall. The bench holds every SCL low phase for ten clocks before changing SDA or raising SCL. It samples SDA in the middle of the SCL high phase, well clear of that latency. Register contents are compared only after the STOP of a transfer, by which time the write strobe has long settled. Fault inputs are changed mid-byte on purpose, so the sampling instant of R5 shows up in the returned bits.

// File: rtl/pwrreg_pkg.sv
package pwrreg_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);
    localparam logic [5:0] DEV_ID_HI = 6'b000101;

    // Control register layout; bit positions matter to the power stages
    typedef struct packed {
        logic       pulse_lim;
        logic       tone_arm;
        logic       tone_cont;
        logic       line_comp;
        logic       v_high;
        logic       out_en;
        logic [1:0] test_w;
    } ctrl_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK
    } link_st_e;

    // Status byte: test bits read zero, three echoed controls, two faults
    function automatic logic [BYTE_W-1:0] status_byte(ctrl_t c, logic otf, logic olf);
        return {3'b000, c.line_comp, c.v_high, c.out_en, otf, olf};
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int PIPE_W = SYNC_STAGES + 1;

    logic [PIPE_W-1:0] scl_pipe;
    logic [PIPE_W-1:0] sda_pipe;
    logic scl_s, scl_d, sda_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[PIPE_W-2:0], scl_i};
            sda_pipe <= {sda_pipe[PIPE_W-2:0], sda_i};
        end
    end

    assign scl_s = scl_pipe[SYNC_STAGES-1];
    assign scl_d = scl_pipe[SYNC_STAGES];
    assign sda_s = sda_pipe[SYNC_STAGES-1];
    assign sda_d = sda_pipe[SYNC_STAGES];

    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/i2c_link_fsm.sv
module i2c_link_fsm
    import pwrreg_pkg::*;
#(
    parameter logic [5:0] ID_HI = DEV_ID_HI
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              supply_ok,
    input  logic              addr_sel,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [BYTE_W-1:0] status_in,
    output logic              drive_low,
    output logic              wr_stb,
    output logic [BYTE_W-1:0] wr_data
);
    link_st_e          state;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] rx_sh;
    logic [BYTE_W-1:0] tx_sh;
    logic              rw_q;
    logic              mack_q;
    logic              full;

    assign full = (cnt == CNT_W'(BYTE_W));

    always_ff @(posedge clk) begin
        if (rst || !supply_ok) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            rx_sh   <= '0;
            tx_sh   <= '0;
            rw_q    <= 1'b0;
            mack_q  <= 1'b0;
            wr_stb  <= 1'b0;
            wr_data <= '0;
        end else begin
            wr_stb <= 1'b0;
            if (start_det) begin
                state <= ST_ADDR;
                cnt   <= '0;
            end else if (stop_det) begin
                state <= ST_IDLE;
                cnt   <= '0;
            end else begin
                case (state)
                    ST_ADDR: begin
                        if (scl_rise && !full) begin
                            rx_sh <= {rx_sh[BYTE_W-2:0], sda_s};
                            cnt   <= cnt + 1'b1;
                        end else if (scl_fall && full) begin
                            cnt <= '0;
                            if (rx_sh[BYTE_W-1:1] == {ID_HI, addr_sel}) begin
                                state <= ST_ADDR_ACK;
                                rw_q  <= rx_sh[0];
                                tx_sh <= status_in;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) state <= rw_q ? ST_RDATA : ST_WDATA;
                    end
                    ST_WDATA: begin
                        if (scl_rise && !full) begin
                            rx_sh <= {rx_sh[BYTE_W-2:0], sda_s};
                            cnt   <= cnt + 1'b1;
                        end else if (scl_fall && full) begin
                            cnt     <= '0;
                            wr_stb  <= 1'b1;
                            wr_data <= rx_sh;
                            state   <= ST_WDATA_ACK;
                        end
                    end
                    ST_WDATA_ACK: begin
                        if (scl_fall) state <= ST_WDATA;
                    end
                    ST_RDATA: begin
                        if (scl_rise && !full) begin
                            cnt <= cnt + 1'b1;
                        end else if (scl_fall) begin
                            if (full) begin
                                cnt   <= '0;
                                state <= ST_RACK;
                            end else begin
                                tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) begin
                            mack_q <= ~sda_s;
                        end else if (scl_fall) begin
                            if (mack_q) begin
                                tx_sh <= status_in;
                                state <= ST_RDATA;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign drive_low = (state == ST_ADDR_ACK) || (state == ST_WDATA_ACK) ||
                       ((state == ST_RDATA) && !tx_sh[BYTE_W-1]);

    // R6
    bit_count_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(BYTE_W));

    // R2
    addr_ack_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(state == ST_ADDR_ACK) |-> $past(state) == ST_ADDR);

    // R7
    lockout_silent_chk: assert property (@(posedge clk) disable iff (rst)
        !supply_ok |=> !drive_low);

    // R8
    start_release_chk: assert property (@(posedge clk) disable iff (rst)
        (start_det && supply_ok) |=> !drive_low);

endmodule

// File: rtl/ctrl_reg.sv
module ctrl_reg
    import pwrreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              supply_ok,
    input  logic              wr_stb,
    input  logic [BYTE_W-1:0] wr_data,
    output ctrl_t             q
);
    always_ff @(posedge clk) begin
        if (rst || !supply_ok) q <= '0;
        else if (wr_stb)       q <= ctrl_t'(wr_data);
    end

    // R7
    lockout_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !supply_ok |=> q == '0);

    // R3
    reg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (supply_ok && !wr_stb) |=> $stable(q));

endmodule

// File: rtl/pwr_ctl_i2c_slave.sv
module pwr_ctl_i2c_slave
    import pwrreg_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [5:0] ID_HI       = DEV_ID_HI
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              supply_ok_i,
    input  logic              addr_sel_i,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic              over_temp_i,
    input  logic              over_load_i,
    output logic [BYTE_W-1:0] ctrl_o
);
    logic sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic drive_low, wr_stb;
    logic [BYTE_W-1:0] wr_data;
    ctrl_t ctrl_q;

    i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2c_link_fsm #(.ID_HI(ID_HI)) fsm_i (
        .clk(clk), .rst(rst), .supply_ok(supply_ok_i), .addr_sel(addr_sel_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det),
        .status_in(status_byte(ctrl_q, over_temp_i, over_load_i)),
        .drive_low(drive_low), .wr_stb(wr_stb), .wr_data(wr_data)
    );

    ctrl_reg reg_i (
        .clk(clk), .rst(rst), .supply_ok(supply_ok_i),
        .wr_stb(wr_stb), .wr_data(wr_data), .q(ctrl_q)
    );

    assign sda_oe_o = drive_low & supply_ok_i;
    assign ctrl_o   = ctrl_q;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (ctrl_o == '0 && !sda_oe_o));

endmodule

// File: tb/pwr_ctl_i2c_slave_tb.sv
module pwr_ctl_i2c_slave_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int Q = 10;
    localparam int WATCHDOG = 190000;

    logic clk = 0, rst = 1;
    logic supply_ok = 1, addr_sel = 0, scl_m = 1, sda_m = 1;
    logic otf = 0, olf = 0;
    logic sda_oe, sda_line;
    logic [7:0] ctrl;
    int errors = 0, checks = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign sda_line = sda_m & ~sda_oe;

    pwr_ctl_i2c_slave dut_i (
        .clk(clk), .rst(rst), .supply_ok_i(supply_ok), .addr_sel_i(addr_sel),
        .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe),
        .over_temp_i(otf), .over_load_i(olf), .ctrl_o(ctrl)
    );

    function automatic logic [7:0] exp_status(logic [7:0] c, logic t, logic l);
        return {3'b000, c[4], c[3], c[2], t, l};
    endfunction

    task automatic check(bit ok, string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic qwait(); repeat (Q) @(negedge clk); endtask
    task automatic bus_start(); sda_m = 1; scl_m = 1; qwait(); sda_m = 0; qwait(); scl_m = 0; qwait(); endtask
    task automatic bus_rstart(); sda_m = 1; qwait(); scl_m = 1; qwait(); sda_m = 0; qwait(); scl_m = 0; qwait(); endtask
    task automatic bus_stop(); sda_m = 0; qwait(); scl_m = 1; qwait(); sda_m = 1; qwait(); endtask
    task automatic send_bit(logic b); sda_m = b; qwait(); scl_m = 1; qwait(); qwait(); scl_m = 0; qwait(); endtask
    task automatic recv_bit(output logic b); sda_m = 1; qwait(); scl_m = 1; qwait(); b = sda_line; qwait(); scl_m = 0; qwait(); endtask

    task automatic write_byte(logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        recv_bit(b);
        ack = ~b;
    endtask

    task automatic read_byte(output logic [7:0] d, input logic mack);
        logic b;
        for (int i = 7; i >= 0; i--) begin recv_bit(b); d[i] = b; end
        send_bit(~mack);
    endtask

    initial begin
        logic ack, ack2;
        logic [7:0] rd, exp_ctrl, d;
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        check(ctrl == 8'h00, "R1", ctrl, 8'h00);
        check(sda_oe == 1'b0, "R1", {7'b0, sda_oe}, 8'h00);

        // R2/R3 directed write, addr_sel low
        bus_start(); write_byte({6'b000101, 1'b0, 1'b0}, ack);
        check(ack, "R2", {7'b0, ack}, 8'h01);
        write_byte(8'hA5, ack2); bus_stop();
        check(ack2, "R3", {7'b0, ack2}, 8'h01);
        check(ctrl == 8'hA5, "R3", ctrl, 8'hA5);
        exp_ctrl = 8'hA5;

        // R4 read layout, test bits hidden
        otf = 1; olf = 0;
        bus_start(); write_byte({6'b000101, 1'b0, 1'b1}, ack);
        read_byte(rd, 1'b0); bus_stop();
        check(rd == exp_status(exp_ctrl, 1, 0), "R4", rd, exp_status(exp_ctrl, 1, 0));

        // R2 wrong address select bit: no ack, no write
        addr_sel = 1;
        bus_start(); write_byte({6'b000101, 1'b0, 1'b0}, ack);
        check(!ack, "R2", {7'b0, ack}, 8'h00);
        write_byte(8'h3C, ack2); bus_stop();
        check(ctrl == exp_ctrl, "R2", ctrl, exp_ctrl);

        // R5/R6 fault sampling and repeated reads
        otf = 0; olf = 1;
        bus_start(); write_byte({6'b000101, 1'b1, 1'b1}, ack);
        send_bit(1'b1); otf = 1; olf = 0;
        for (int i = 6; i >= 0; i--) recv_bit(rd[i]);
        send_bit(1'b0);
        check(rd[6:0] == exp_status(exp_ctrl, 0, 1) & 8'h7F, "R5", rd, exp_status(exp_ctrl, 0, 1));
        read_byte(rd, 1'b0);
        check(rd == exp_status(exp_ctrl, 1, 0), "R6", rd, exp_status(exp_ctrl, 1, 0));
        repeat (3 * Q) @(negedge clk);
        check(sda_oe == 1'b0, "R6", {7'b0, sda_oe}, 8'h00);
        bus_stop();

        // R8 repeated start: write then read in one transfer
        bus_start(); write_byte({6'b000101, 1'b1, 1'b0}, ack);
        write_byte(8'h1C, ack2);
        bus_rstart(); write_byte({6'b000101, 1'b1, 1'b1}, ack);
        check(ack, "R8", {7'b0, ack}, 8'h01);
        read_byte(rd, 1'b0); bus_stop();
        exp_ctrl = 8'h1C;
        check(rd == exp_status(exp_ctrl, 1, 0), "R8", rd, exp_status(exp_ctrl, 1, 0));
        // R8 STOP mid-byte discards partial data
        bus_start(); write_byte({6'b000101, 1'b1, 1'b0}, ack);
        send_bit(1); send_bit(1); send_bit(1); bus_stop();
        repeat (2 * Q) @(negedge clk);
        check(ctrl == exp_ctrl, "R8", ctrl, exp_ctrl);

        // R7 lockout
        supply_ok = 0;
        repeat (3) @(negedge clk);
        check(ctrl == 8'h00, "R7", ctrl, 8'h00);
        bus_start(); write_byte({6'b000101, 1'b1, 1'b0}, ack);
        check(!ack, "R7", {7'b0, ack}, 8'h00);
        write_byte(8'hFF, ack2); bus_stop();
        check(!ack2 && ctrl == 8'h00, "R7", ctrl, 8'h00);
        supply_ok = 1; exp_ctrl = 8'h00;
        repeat (5) @(negedge clk);
        bus_start(); write_byte({6'b000101, 1'b1, 1'b1}, ack);
        read_byte(rd, 1'b0); bus_stop();
        check(rd == exp_status(8'h00, otf, olf), "R7", rd, exp_status(8'h00, otf, olf));

        // Random mix, R3/R4/R2
        for (int n = 0; n < 30; n++) begin
            logic s, good;
            s = 1'($urandom); good = ($urandom % 5) != 0;
            addr_sel = s; d = 8'($urandom);
            otf = 1'($urandom); olf = 1'($urandom);
            bus_start(); write_byte({6'b000101, good ? s : ~s, 1'b0}, ack);
            check(ack == good, "R2", {7'b0, ack}, {7'b0, good});
            if (ack) write_byte(d, ack2);
            bus_stop();
            if (good) exp_ctrl = d;
            repeat (2 * Q) @(negedge clk);
            check(ctrl == exp_ctrl, "R3", ctrl, exp_ctrl);
            bus_start(); write_byte({6'b000101, s, 1'b1}, ack);
            read_byte(rd, 1'b0); bus_stop();
            check(rd == exp_status(exp_ctrl, otf, olf), "R4", rd, exp_status(exp_ctrl, otf, olf));
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule